// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps the two 16-bit data pointers of a small 8-bit microcontroller core, together with the select bit that decides which pointer counts as current. Software reaches the pointers through four byte addresses on the special-function-register bus. One address pair always shows the current pointer. The other pair always shows the alternate pointer. When the select bit changes, the two pointers trade places between the address pairs.

The decoder sends the block one strobe for each instruction event. A prefix strobe arms a one-shot flag. While the flag is armed, the next pointer instruction works on the pointer opposite to the one chosen by the select bit. The indirect jump does not honour the flag. The block presents the effective 16-bit address on every cycle, and it applies increments and 16-bit loads to the effective pointer.

The select bit lives in a control register. In that register, bit 1 and bit 2 always read as zero. Software can therefore flip the select bit by reading the register, adding one and writing the result back, and the flag bits above stay unchanged.

Top module: `dptr_pair_unit`

## Requirements
- R1: After reset, both pointers, the select bit, the control flags and the prefix flag are zero. Every mapped address reads 0x00, and `ptr_addr` is 0x0000.
- R2: Address 0x82 reads and writes the low byte of the current pointer, and 0x83 reads and writes its high byte. Address 0xD4 reads and writes the low byte of the alternate pointer, and 0xD5 its high byte. The current pointer is pointer 0 when select=0 and pointer 1 when select=1.
- R3: The select bit is bit 0 of the control register at 0xA2. Writing it exchanges which pointer appears at 0x82/0x83 and which appears at 0xD4/0xD5. The stored pointer values do not change.
- R4: In the control register, bits 2 and 1 always read 0 and ignore writes. Bits 7:3 hold the value last written to them. Writing back the value read plus one toggles bit 0 and leaves bits 7:3 unchanged.
- R5: A prefix strobe makes the next instruction use the pointer opposite to the select bit, both for `ptr_addr` and for any update. The prefix strobe does not change the select bit.
- R6: The prefix flag clears when the next instruction completes (`ins_end`), even if that instruction touches no pointer.
- R7: During an indirect jump (`ins_jmp`), `ptr_addr` shows the pointer chosen by the select bit, whether or not the prefix flag is armed.
- R8: An increment adds one to the full 16-bit effective pointer. 0xFFFF becomes 0x0000, and no other state changes.
- R9: A load writes `ins_ld_val` into the effective pointer. When a load and an increment arrive in the same instruction, the load takes effect.
- R10: When an SFR byte write and an instruction update hit the same pointer in the same cycle, the instruction result is stored. An SFR write to the other pointer in that cycle still takes effect.
- R11: Addresses outside 0x82, 0x83, 0xD4, 0xD5 and 0xA2 read 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR byte address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` (combinational) |
| ins_prefix | input | 1 | Opposite-pointer prefix byte seen |
| ins_end | input | 1 | An instruction completes this cycle |
| ins_jmp | input | 1 | The completing instruction is the indirect jump |
| ins_inc | input | 1 | The completing instruction increments the pointer |
| ins_load | input | 1 | The completing instruction loads the pointer |
| ins_ld_val | input | 16 | Value for a pointer load |
| ptr_addr | output | 16 | Effective pointer value |

## Verification
The case that matters most is an SFR byte write and an instruction update arriving at one pointer in the same cycle. This is provoked both directly and through the prefix. With the prefix, a write to the alternate address pair and an increment of the inverted pointer land on the same register. The bench reads the bytes back afterwards. It judges each result against a model that computes the instruction update from the old pointer value and then discards the SFR byte. The second collision tested is a prefix strobe arriving in the same cycle as a control-register write, to confirm that the select bit comes only from the bus.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  localparam int PTR_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int NPTR      = 2;
  localparam int CTL_FLAGS = BYTE_W - 3;

  typedef logic [PTR_W-1:0]     ptr_t;
  typedef logic [BYTE_W-1:0]    byte_t;
  typedef logic [CTL_FLAGS-1:0] flags_t;

  typedef enum logic [2:0] {
    SFR_NONE,
    SFR_CUR_LO,
    SFR_CUR_HI,
    SFR_ALT_LO,
    SFR_ALT_HI,
    SFR_CTL
  } sfr_kind_e;

  function automatic ptr_t ptr_next(input ptr_t p);
    return p + ptr_t'(1);
  endfunction

  function automatic ptr_t byte_merge(input ptr_t p, input logic hi, input byte_t b);
    ptr_t r;
    r = p;
    if (hi) r[PTR_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]     = b;
    return r;
  endfunction

  function automatic byte_t byte_pick(input ptr_t p, input logic hi);
    return hi ? p[PTR_W-1:BYTE_W] : p[BYTE_W-1:0];
  endfunction

  function automatic byte_t ctl_pack(input flags_t f, input logic s);
    return {f, 2'b00, s};
  endfunction

endpackage

// File: rtl/dpu_ctl_reg.sv
module dpu_ctl_reg
  import dpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr,
  input  logic   wsel,
  input  flags_t wflags,
  output logic   sel,
  output byte_t  rdata
);

  flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= 1'b0;
      flags_q <= '0;
    end else if (wr) begin
      sel     <= wsel;
      flags_q <= wflags;
    end
  end

  assign rdata = ctl_pack(flags_q, sel);

  // R4
  ctl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[2:1] == 2'b00) && (rdata[0] == $past(wsel)) &&
           (rdata[BYTE_W-1:3] == $past(wflags)));

endmodule

// File: rtl/dpu_prefix_trk.sv
module dpu_prefix_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic pfx_seen,
  input  logic ins_end,
  input  logic ins_jmp,
  input  logic sel,
  output logic armed,
  output logic eff_sel
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (pfx_seen) armed <= 1'b1;
    else if (ins_end)  armed <= 1'b0;
  end

  assign eff_sel = sel ^ (armed & ~ins_jmp);

  // R5
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_seen |=> armed);

  // R6
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_end && !pfx_seen) |=> !armed);

endmodule

// File: rtl/dpu_ptr_slot.sv
module dpu_ptr_slot
  import dpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  byte_t wdata,
  input  logic  ins_inc,
  input  logic  ins_load,
  input  ptr_t  ld_val,
  output ptr_t  val
);

  ptr_t nxt;

  always_comb begin
    nxt = val;
    if (wr_lo) nxt = byte_merge(nxt, 1'b0, wdata);
    if (wr_hi) nxt = byte_merge(nxt, 1'b1, wdata);
    if (ins_load)     nxt = ld_val;
    else if (ins_inc) nxt = ptr_next(val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_load |=> val == $past(ld_val));

  // R8 R10
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_inc && !ins_load) |=> val == ptr_t'($past(val) + ptr_t'(1)));

  // R11
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi || ins_inc || ins_load) |=> $stable(val));

endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit
  import dpu_pkg::*;
#(
  parameter logic [7:0] ADDR_CUR_LO = 8'h82,
  parameter logic [7:0] ADDR_CUR_HI = 8'h83,
  parameter logic [7:0] ADDR_ALT_LO = 8'hD4,
  parameter logic [7:0] ADDR_ALT_HI = 8'hD5,
  parameter logic [7:0] ADDR_CTL    = 8'hA2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  input  logic        ins_prefix,
  input  logic        ins_end,
  input  logic        ins_jmp,
  input  logic        ins_inc,
  input  logic        ins_load,
  input  logic [15:0] ins_ld_val,
  output logic [15:0] ptr_addr
);

  sfr_kind_e kind;
  logic      sel_q;
  logic      pfx_armed;
  logic      eff_sel;
  byte_t     ctl_rdata;
  logic      ctl_wr;
  ptr_t      ptr_q [NPTR];
  ptr_t      cur_val;
  ptr_t      alt_val;
  logic      ctl_wd_unused;

  always_comb begin
    unique case (sfr_addr)
      ADDR_CUR_LO: kind = SFR_CUR_LO;
      ADDR_CUR_HI: kind = SFR_CUR_HI;
      ADDR_ALT_LO: kind = SFR_ALT_LO;
      ADDR_ALT_HI: kind = SFR_ALT_HI;
      ADDR_CTL:    kind = SFR_CTL;
      default:     kind = SFR_NONE;
    endcase
  end

  assign ctl_wr        = sfr_wr && (kind == SFR_CTL);
  assign ctl_wd_unused = ^sfr_wdata[2:1];

  dpu_ctl_reg i_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (ctl_wr),
    .wsel   (sfr_wdata[0]),
    .wflags (sfr_wdata[BYTE_W-1:3]),
    .sel    (sel_q),
    .rdata  (ctl_rdata)
  );

  dpu_prefix_trk i_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pfx_seen (ins_prefix),
    .ins_end  (ins_end),
    .ins_jmp  (ins_jmp),
    .sel      (sel_q),
    .armed    (pfx_armed),
    .eff_sel  (eff_sel)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_slot
    logic is_cur;
    logic hit;
    logic wr_lo;
    logic wr_hi;

    assign is_cur = (sel_q == 1'(g));
    assign hit    = ins_end && (eff_sel == 1'(g));
    assign wr_lo  = sfr_wr && ((kind == SFR_CUR_LO &&  is_cur) ||
                               (kind == SFR_ALT_LO && !is_cur));
    assign wr_hi  = sfr_wr && ((kind == SFR_CUR_HI &&  is_cur) ||
                               (kind == SFR_ALT_HI && !is_cur));

    dpu_ptr_slot i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wdata    (sfr_wdata),
      .ins_inc  (hit && ins_inc),
      .ins_load (hit && ins_load),
      .ld_val   (ins_ld_val),
      .val      (ptr_q[g])
    );
  end

  assign cur_val  = ptr_q[sel_q];
  assign alt_val  = ptr_q[~sel_q];
  assign ptr_addr = ptr_q[eff_sel];

  always_comb begin
    unique case (kind)
      SFR_CUR_LO: sfr_rdata = byte_pick(cur_val, 1'b0);
      SFR_CUR_HI: sfr_rdata = byte_pick(cur_val, 1'b1);
      SFR_ALT_LO: sfr_rdata = byte_pick(alt_val, 1'b0);
      SFR_ALT_HI: sfr_rdata = byte_pick(alt_val, 1'b1);
      SFR_CTL:    sfr_rdata = ctl_rdata;
      default:    sfr_rdata = '0;
    endcase
  end

  // R7
  jmp_ignores_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_jmp |-> ptr_addr == (sel_q ? ptr_q[1] : ptr_q[0]));

  // R5 R3
  sel_only_by_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(sel_q));

endmodule

// File: tb/test_dptr_pair_unit.sv
module test_dptr_pair_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  sfr_wdata = '0;
  logic [7:0]  sfr_rdata;
  logic        ins_prefix = 1'b0;
  logic        ins_end = 1'b0;
  logic        ins_jmp = 1'b0;
  logic        ins_inc = 1'b0;
  logic        ins_load = 1'b0;
  logic [15:0] ins_ld_val = '0;
  logic [15:0] ptr_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dptr_pair_unit i_dptr_pair_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rdata  (sfr_rdata),
    .ins_prefix (ins_prefix),
    .ins_end    (ins_end),
    .ins_jmp    (ins_jmp),
    .ins_inc    (ins_inc),
    .ins_load   (ins_load),
    .ins_ld_val (ins_ld_val),
    .ptr_addr   (ptr_addr)
  );

  typedef struct {
    logic [15:0] exp_addr;
    logic [7:0]  exp_rd;
    string       req;
  } item_t;

  item_t q[$];

  // bench model of the requirements
  logic [15:0] mp [2];
  logic        msel;
  logic [4:0]  mfl;
  logic        mpfx;

  function automatic logic [7:0] m_read(input logic [7:0] a);
    case (a)
      8'h82:   return mp[msel][7:0];
      8'h83:   return mp[msel][15:8];
      8'hD4:   return mp[!msel][7:0];
      8'hD5:   return mp[!msel][15:8];
      8'hA2:   return {mfl, 1'b0, 1'b0, msel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic wr, input logic [7:0] a, input logic [7:0] d,
                      input logic pf, input logic en, input logic jp,
                      input logic ic, input logic ld, input logic [15:0] lv,
                      input string req);
    item_t it;
    logic        es;
    logic [15:0] old [2];
    @(negedge clk);
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
    ins_prefix = pf; ins_end = en; ins_jmp = jp; ins_inc = ic; ins_load = ld;
    ins_ld_val = lv;
    es = msel ^ (mpfx & ~jp);
    it.exp_addr = mp[es];
    it.exp_rd   = m_read(a);
    it.req      = req;
    q.push_back(it);
    old[0] = mp[0]; old[1] = mp[1];
    if (wr) begin
      case (a)
        8'h82: mp[msel][7:0]   = d;
        8'h83: mp[msel][15:8]  = d;
        8'hD4: mp[!msel][7:0]  = d;
        8'hD5: mp[!msel][15:8] = d;
        default: ;
      endcase
    end
    if (en && ld)      mp[es] = lv;
    else if (en && ic) mp[es] = old[es] + 16'd1;
    if (wr && a == 8'hA2) begin
      msel = d[0];
      mfl  = d[7:3];
    end
    if (pf)      mpfx = 1'b1;
    else if (en) mpfx = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string req);
    step(1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, req);
  endtask

  task automatic rd_all(input string req);
    rd(8'h82, req); rd(8'h83, req); rd(8'hD4, req); rd(8'hD5, req); rd(8'hA2, req);
  endtask

  // monitor: scoreboard compare in the low phase
  always @(negedge clk) begin
    #3;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (ptr_addr !== it.exp_addr) begin
        errors++;
        $display("FAIL %s ptr_addr actual %h expected %h", it.req, ptr_addr, it.exp_addr);
      end
      checks++;
      if (sfr_rdata !== it.exp_rd) begin
        errors++;
        $display("FAIL %s sfr_rdata actual %h expected %h", it.req, sfr_rdata, it.exp_rd);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mp[0] = '0; mp[1] = '0; msel = 1'b0; mfl = '0; mpfx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_all("R1");
    // R2 byte mapping with select=0
    wr(8'h82, 8'h34, "R2"); wr(8'h83, 8'h12, "R2");
    wr(8'hD4, 8'h78, "R2"); wr(8'hD5, 8'h56, "R2");
    rd_all("R2");
    // R3 select swap
    wr(8'hA2, 8'h01, "R3");
    rd_all("R3");
    wr(8'hA2, 8'h00, "R3");
    rd_all("R3");
    // R4 hard zero bits and read-plus-one toggle
    wr(8'hA2, 8'hFF, "R4"); rd(8'hA2, "R4");
    wr(8'hA2, m_read(8'hA2) + 8'd1, "R4"); rd(8'hA2, "R4");
    wr(8'hA2, m_read(8'hA2) + 8'd1, "R4"); rd_all("R4");
    // R5 prefix inverts one load, select untouched; prefix with ctl write collision
    step(1'b0, 8'hA2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R5");
    step(1'b0, 8'hA2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hBEEF, "R5");
    rd_all("R5");
    step(1'b1, 8'hA2, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R5");
    rd(8'hA2, "R5");
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R5");
    rd_all("R5");
    // R6 prefix clears on a non-pointer instruction
    step(1'b0, 8'h82, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R6");
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R6");
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R6");
    rd_all("R6");
    // R7 indirect jump ignores prefix
    step(1'b0, 8'hD4, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R7");
    step(1'b0, 8'hD4, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0, "R7");
    rd(8'h82, "R7");
    // R8 wrap on increment
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF, "R8");
    step(1'b0, 8'h83, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R8");
    rd_all("R8");
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h00FF, "R8");
    step(1'b0, 8'h83, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R8");
    rd_all("R8");
    // R9 load beats increment
    step(1'b0, 8'h82, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h4321, "R9");
    rd_all("R9");
    // R10 instruction beats SFR write on same pointer; other pointer write lands
    step(1'b1, 8'h82, 8'hAA, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
    rd_all("R10");
    step(1'b1, 8'hD5, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
    rd_all("R10");
    step(1'b0, 8'hD4, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, "R10");
    step(1'b1, 8'hD4, 8'h11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R10");
    rd_all("R10");
    step(1'b1, 8'h83, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 16'h9000, "R10");
    rd_all("R10");
    // R11 unmapped addresses
    wr(8'h90, 8'hFF, "R11"); wr(8'h84, 8'h55, "R11");
    rd(8'h90, "R11"); rd(8'h84, "R11"); rd(8'h00, "R11");
    rd_all("R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule